// File: doc/BRIEF.md
# Burst Control Word Inserter

This block is the transmit-side scheduler of a packet-streaming link. It decides, cycle by cycle, whether the next 64-bit word on its output is a data word taken from the local bus or a control word. A control word is placed between bursts and after every packet. Each control word also carries a slice of an XON/XOFF flow-control calendar. Upstream logic presents beats of data with enable, start, end, error and empty-byte fields. It holds a beat until the block raises `in_ready`. A burst limit input caps how many data words may pass between two control words. A force input lets an external scheduler ask for a burst boundary earlier than the limit would.

There is one register stage from the decision to the output. Each cycle in which the output side is ready produces exactly one word. The word is either the accepted data, a burst or end-of-packet control word, or an idle control word when nothing is offered. Two status pulses report an input side that runs dry in the middle of a packet (underflow) and data offered while the output side stalls (overflow). Neither pulse should ever appear in a correctly clocked system.

Control word layout: bit 63 = 1 for burst and end-of-packet words, 0 for idle words. Bit 56 is the calendar restart flag. Bits 55:48 hold the calendar slice. Bit 44 is the end-of-packet flag, bit 43 the error flag, and bits 42:39 the effective empty-byte count. All other bits are 0.

Top module: `bcw_inserter`

## Requirements
- R1: A data beat accepted in a cycle (`in_ena` and `in_ready` high) appears unchanged on `out_word` on the next cycle, with `out_is_ctl` low and `out_valid` high.
- R2: When `in_ena` and `in_force` are high and the previous output word was data, `in_ready` is low and the next output word is a burst control word (bit 63 = 1, bit 44 = 0). The beat is accepted on the following cycle.
- R3: With `cfg_burst_max` = N ≥ 1, after N data words have passed since the last control word, a burst control word is emitted before the next data word, and `in_ready` is low in that cycle.
- R4: Every control word, including idle and end-of-packet words, restarts the burst count from zero.
- R5: Control word k (counting from reset, all kinds) carries `fc_status[8m+7:8m]` in bits 55:48, where m = k mod 32. A 1 means XON and a 0 means XOFF.
- R6: Bit 56 of a control word is 1 exactly when it carries calendar slice m = 0.
- R7: After a data word accepted with `in_eop` high, the next output word is a control word with bit 63 = 1 and bit 44 = 1, and bit 43 equal to the beat's `in_err`. `in_ready` is low in the cycle that word is produced.
- R8: The end-of-packet word carries the beat's `in_mty` in bits 42:39. When `in_err` was also high, the low three bits are 000 and bit 3 is kept.
- R9: In a ready cycle with no beat offered and no pending end-of-packet word, an idle control word (bit 63 = 0, bit 44 = 0) is emitted.
- R10: `stat_underflow` pulses one cycle after a ready cycle that falls inside a packet (a start beat accepted, its end beat not yet accepted) with `in_ena` low and no pending end-of-packet word.
- R11: While `out_ready` is low, `in_ready` is low and the output holds with `out_valid` low. If `in_ena` is high in such a cycle, `stat_overflow` pulses on the next cycle.
- R12: During reset, `out_valid`, `stat_underflow` and `stat_overflow` are low, and the calendar starts at slice 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 64 | Data beat |
| in_ena | input | 1 | Beat offered |
| in_sop | input | 1 | Beat starts a packet |
| in_eop | input | 1 | Beat ends a packet |
| in_err | input | 1 | Packet ended in error (used with in_eop) |
| in_mty | input | 4 | Empty bytes in the last beat |
| in_force | input | 1 | Request a burst control word before this beat |
| in_ready | output | 1 | Beat taken this cycle |
| cfg_burst_max | input | CNT_W (8) | Data words allowed between control words |
| fc_status | input | FC_POS (256) | Flow-control calendar, 1 = XON |
| out_ready | input | 1 | Output side can take a word |
| out_valid | output | 1 | A word was produced in the last cycle |
| out_word | output | 64 | Output word |
| out_is_ctl | output | 1 | Output word is a control word |
| stat_underflow | output | 1 | Input ran dry inside a packet |
| stat_overflow | output | 1 | Beat offered while output stalled |

## Verification
The bench targets the cases where two reasons for a control word meet. A force request that arrives just after a control word must not produce a second control word. A design that ignored the previous word would stall a held force beat forever. A beat offered while an end-of-packet word is still pending must wait. A design that gave the limit or the data priority over the pending word would lose the packet's end marker. The error-masked empty count is checked with bit 3 both set and clear, since a design that zeroed the whole field, or none of it, passes a test that uses only small counts. The calendar is followed past its 32-word wrap, and a burst count that is not cleared by idle words shows up as a spurious burst word in a directed run.

// File: rtl/bcw_pkg.sv
package bcw_pkg;
  localparam int WORD_W = 64;
  localparam int MTY_W  = 4;

  // control word field positions
  localparam int CW_BURST  = 63;
  localparam int CW_CALRST = 56;
  localparam int CW_FC_HI  = 55;
  localparam int CW_FC_LO  = 48;
  localparam int CW_EOP    = 44;
  localparam int CW_ERR    = 43;
  localparam int CW_MTY_HI = 42;
  localparam int CW_MTY_LO = 39;

  typedef enum logic [1:0] {
    K_DATA  = 2'd0,
    K_IDLE  = 2'd1,
    K_BURST = 2'd2,
    K_EOP   = 2'd3
  } word_kind_e;

  // empty-byte count seen by the receiver: error at end masks the low three bits
  function automatic logic [MTY_W-1:0] eff_mty(input logic [MTY_W-1:0] mty,
                                               input logic eop, input logic err);
    logic [MTY_W-1:0] r;
    r = mty;
    if (eop && err) r[2:0] = 3'b000;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] ctl_word(input logic is_burst,
                                                 input logic cal_rst,
                                                 input logic [7:0] fc,
                                                 input logic eop,
                                                 input logic err,
                                                 input logic [MTY_W-1:0] mty);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CW_BURST]              = is_burst;
    w[CW_CALRST]             = cal_rst;
    w[CW_FC_HI:CW_FC_LO]     = fc;
    w[CW_EOP]                = eop;
    w[CW_ERR]                = err;
    w[CW_MTY_HI:CW_MTY_LO]   = mty;
    return w;
  endfunction
endpackage

// File: rtl/bcw_calendar.sv
module bcw_calendar #(
  parameter int FC_POS = 256,
  parameter int FC_PER = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [FC_POS-1:0] fc_status,
  output logic [FC_PER-1:0] fc_bits,
  output logic              at_start
);
  localparam int SLOTS = FC_POS / FC_PER;
  localparam int CAL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [CAL_W-1:0] LAST = CAL_W'(SLOTS - 1);

  logic [CAL_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ptr <= '0;
    else if (adv)        ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  assign fc_bits  = fc_status[int'(ptr)*FC_PER +: FC_PER];
  assign at_start = (ptr == '0);

  p_cal_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr == LAST) |=> at_start);
  p_cal_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));
endmodule

// File: rtl/bcw_burst_ctr.sv
module bcw_burst_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_go,
  input  logic             ctl_go,
  input  logic [CNT_W-1:0] max_words,
  output logic             at_limit
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (ctl_go)                cnt <= '0;
    else if (data_go && cnt != '1)  cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt >= max_words);

  // a data word never passes once the limit has been used up
  p_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_go && max_words != '0) |-> (cnt < max_words));
  p_ctl_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_go |=> (cnt == '0));
endmodule

// File: rtl/bcw_flags.sv
module bcw_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic in_ena,
  input  logic out_ready,
  input  logic in_pkt,
  input  logic pend_eop,
  output logic underflow,
  output logic overflow
);
  logic uf_ev, of_ev;

  assign uf_ev = in_pkt && !in_ena && out_ready && !pend_eop;
  assign of_ev = in_ena && !out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      underflow <= uf_ev;
      overflow  <= of_ev;
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(in_ena && !out_ready));
  p_underflow_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(in_pkt && out_ready));
endmodule

// File: rtl/bcw_inserter.sv
module bcw_inserter
  import bcw_pkg::*;
#(
  parameter int FC_POS = 256,
  parameter int FC_PER = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_ena,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_err,
  input  logic [MTY_W-1:0]  in_mty,
  input  logic              in_force,
  output logic              in_ready,
  input  logic [CNT_W-1:0]  cfg_burst_max,
  input  logic [FC_POS-1:0] fc_status,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_is_ctl,
  output logic              stat_underflow,
  output logic              stat_overflow
);
  // named internal events
  logic              at_limit, ins_need, take, ctl_go, data_go;
  logic              ctl_last, pend_eop, in_pkt;
  logic              eop_err;
  logic [MTY_W-1:0]  eop_mty;
  logic [FC_PER-1:0] fc_bits;
  logic              cal_at_start;
  word_kind_e        kind;

  assign ins_need = in_ena && (in_force || at_limit) && !ctl_last;

  always_comb begin
    if (pend_eop)      kind = K_EOP;
    else if (ins_need) kind = K_BURST;
    else if (in_ena)   kind = K_DATA;
    else               kind = K_IDLE;
  end

  assign in_ready = out_ready && !pend_eop && !ins_need;
  assign take     = in_ena && in_ready;
  assign data_go  = take;
  assign ctl_go   = out_ready && (kind != K_DATA);

  bcw_calendar #(.FC_POS(FC_POS), .FC_PER(FC_PER)) u_cal (
    .clk(clk), .rst_n(rst_n), .adv(ctl_go), .fc_status(fc_status),
    .fc_bits(fc_bits), .at_start(cal_at_start)
  );

  bcw_burst_ctr #(.CNT_W(CNT_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .data_go(data_go), .ctl_go(ctl_go),
    .max_words(cfg_burst_max), .at_limit(at_limit)
  );

  bcw_flags u_flags (
    .clk(clk), .rst_n(rst_n), .in_ena(in_ena), .out_ready(out_ready),
    .in_pkt(in_pkt), .pend_eop(pend_eop),
    .underflow(stat_underflow), .overflow(stat_overflow)
  );

  // packet tracking and end-of-packet capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_eop <= 1'b0;
      eop_err  <= 1'b0;
      eop_mty  <= '0;
      in_pkt   <= 1'b0;
    end else begin
      if (take && in_eop) begin
        pend_eop <= 1'b1;
        eop_err  <= in_err;
        eop_mty  <= eff_mty(in_mty, in_eop, in_err);
      end else if (ctl_go && kind == K_EOP) begin
        pend_eop <= 1'b0;
      end
      if (take && in_eop)      in_pkt <= 1'b0;
      else if (take && in_sop) in_pkt <= 1'b1;
    end
  end

  // output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_word   <= '0;
      out_is_ctl <= 1'b0;
      ctl_last   <= 1'b1;
    end else if (!out_ready) begin
      out_valid  <= 1'b0;
    end else begin
      out_valid  <= 1'b1;
      out_is_ctl <= (kind != K_DATA);
      ctl_last   <= (kind != K_DATA);
      unique case (kind)
        K_DATA:  out_word <= in_data;
        K_IDLE:  out_word <= ctl_word(1'b0, cal_at_start, fc_bits, 1'b0, 1'b0, '0);
        K_BURST: out_word <= ctl_word(1'b1, cal_at_start, fc_bits, 1'b0, 1'b0, '0);
        default: out_word <= ctl_word(1'b1, cal_at_start, fc_bits, 1'b1, eop_err, eop_mty);
      endcase
    end
  end

  p_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_valid && !out_is_ctl && out_word == $past(in_data)));
  p_force_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ena && in_force && out_ready && !pend_eop && !ctl_last)
      |=> (out_is_ctl && out_word[CW_BURST] && !out_word[CW_EOP]));
  p_eop_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_eop && out_ready) |=> (out_is_ctl && out_word[CW_EOP]));
  p_eop_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_eop |-> !in_ready);
  p_mty_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_eop && in_err) |=> (eop_mty[2:0] == 3'b000));
  p_cal_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_go && cal_at_start) |=> out_word[CW_CALRST]);
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> (!out_valid && $stable(out_word)));
  p_no_ctl_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_last && in_ena && out_ready && !pend_eop) |-> in_ready);
endmodule

// File: tb/bcw_inserter_tb_top.sv
`timescale 1ns/1ps
module bcw_inserter_tb_top;
  typedef struct packed {
    logic       ena, sop, eop, err, frc, ordy;
    logic [3:0] mty;
    logic       rdy;
    logic [2:0] kind;  // 0 data, 1 idle, 2 burst, 3 eop, 4 stall
    logic [3:0] emty;
    logic       eerr, uf, of;
  } vec_t;

  function automatic vec_t mkv(input int ena, sop, eop, err, frc, ordy, mty,
                               rdy, kind, emty, eerr, uf, of);
    vec_t v;
    v.ena = 1'(ena); v.sop = 1'(sop); v.eop = 1'(eop); v.err = 1'(err);
    v.frc = 1'(frc); v.ordy = 1'(ordy); v.mty = 4'(mty); v.rdy = 1'(rdy);
    v.kind = 3'(kind); v.emty = 4'(emty); v.eerr = 1'(eerr);
    v.uf = 1'(uf); v.of = 1'(of);
    return v;
  endfunction

  localparam int NV = 19;
  //                       ena sop eop err frc ordy mty rdy kind emty eerr uf of
  localparam vec_t TBL [NV] = '{
    mkv(0,0,0,0,0,1, 0, 1,1, 0,0,0,0),   // idle word
    mkv(1,1,0,0,0,1, 0, 1,0, 0,0,0,0),   // start, data 1
    mkv(1,0,0,0,0,1, 0, 1,0, 0,0,0,0),   // data 2
    mkv(1,0,0,0,0,1, 0, 1,0, 0,0,0,0),   // data 3 (limit reached)
    mkv(1,0,0,0,0,1, 0, 0,2, 0,0,0,0),   // limit burst word
    mkv(1,0,0,0,0,1, 0, 1,0, 0,0,0,0),   // beat goes through
    mkv(1,0,0,0,1,1, 0, 0,2, 0,0,0,0),   // forced burst word
    mkv(1,0,0,0,1,1, 0, 1,0, 0,0,0,0),   // force held, just after ctl: data
    mkv(1,0,1,0,0,1, 5, 1,0, 0,0,0,0),   // end, mty 5
    mkv(1,1,0,0,0,1, 0, 0,3, 5,0,0,0),   // pending end word wins
    mkv(1,1,0,0,0,1, 0, 1,0, 0,0,0,0),   // new start
    mkv(0,0,0,0,0,1, 0, 1,1, 0,0,1,0),   // gap inside packet
    mkv(1,0,1,1,0,1,13, 1,0, 0,0,0,0),   // end with error, mty 1101
    mkv(0,0,0,0,0,1, 0, 0,3, 8,1,0,0),   // masked to 1000
    mkv(1,1,0,0,0,0, 0, 0,4, 0,0,0,1),   // offered during stall
    mkv(1,1,0,0,0,1, 0, 1,0, 0,0,0,0),   // start after stall
    mkv(1,0,1,1,0,1, 3, 1,0, 0,0,0,0),   // end with error, mty 0011
    mkv(0,0,0,0,0,1, 0, 0,3, 0,1,0,0),   // masked to 0000
    mkv(0,0,0,0,0,1, 0, 1,1, 0,0,0,0)    // idle
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [63:0]  in_data = '0;
  logic         in_ena = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
  logic [3:0]   in_mty = '0;
  logic         in_force = 1'b0;
  logic         in_ready;
  logic [7:0]   cfg_burst_max = 8'd3;
  logic [255:0] fc_status;
  logic         out_ready = 1'b1;
  logic         out_valid;
  logic [63:0]  out_word;
  logic         out_is_ctl, stat_underflow, stat_overflow;

  int n_chk = 0;
  int n_fail = 0;
  int cal_k = 0;
  int wraps = 0;

  always #4 clk = ~clk;

  bcw_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ena(in_ena),
    .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err), .in_mty(in_mty),
    .in_force(in_force), .in_ready(in_ready), .cfg_burst_max(cfg_burst_max),
    .fc_status(fc_status), .out_ready(out_ready), .out_valid(out_valid),
    .out_word(out_word), .out_is_ctl(out_is_ctl),
    .stat_underflow(stat_underflow), .stat_overflow(stat_overflow)
  );

  function automatic logic [7:0] fc_byte(input int k);
    return 8'(k * 37 + 11);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check in_ready, then check registered outputs
  task automatic step(input vec_t v, input logic [63:0] dat);
    in_ena = v.ena; in_sop = v.sop; in_eop = v.eop; in_err = v.err;
    in_force = v.frc; out_ready = v.ordy; in_mty = v.mty; in_data = dat;
    #1;
    chk(in_ready == v.rdy, "R2/R3/R7/R11", "in_ready", 64'(in_ready), 64'(v.rdy));
    @(posedge clk);
    @(negedge clk);
    case (v.kind)
      3'd0: chk(out_valid && !out_is_ctl && out_word == dat, "R1", "data word",
                out_word, dat);
      3'd1: chk(out_valid && out_is_ctl && !out_word[63] && !out_word[44], "R9",
                "idle word", out_word, 64'h0);
      3'd2: chk(out_valid && out_is_ctl && out_word[63] && !out_word[44], "R2/R3",
                "burst word", out_word, 64'h8000_0000_0000_0000);
      3'd3: begin
        chk(out_valid && out_is_ctl && out_word[63] && out_word[44], "R7",
            "end word", out_word, 64'h8000_1000_0000_0000);
        chk(out_word[43] == v.eerr, "R7", "end error bit",
            64'(out_word[43]), 64'(v.eerr));
        chk(out_word[42:39] == v.emty, "R8", "empty count",
            64'(out_word[42:39]), 64'(v.emty));
      end
      default: chk(!out_valid, "R11", "stall out_valid", 64'(out_valid), 64'h0);
    endcase
    if (v.kind != 3'd4 && out_is_ctl) begin
      chk(out_word[55:48] == fc_byte(cal_k), "R5", "calendar slice",
          64'(out_word[55:48]), 64'(fc_byte(cal_k)));
      chk(out_word[56] == (cal_k == 0), "R6", "calendar restart",
          64'(out_word[56]), 64'(cal_k == 0));
      if (cal_k == 31) wraps++;
      cal_k = (cal_k + 1) % 32;
    end
    chk(stat_underflow == v.uf, "R10", "underflow", 64'(stat_underflow), 64'(v.uf));
    chk(stat_overflow == v.of, "R11", "overflow", 64'(stat_overflow), 64'(v.of));
  endtask

  initial begin
    for (int k = 0; k < 32; k++) fc_status[k*8 +: 8] = fc_byte(k);
  end

  initial begin : watchdog
    #(8 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!out_valid, "R12", "out_valid in reset", 64'(out_valid), 64'h0);
    chk(!stat_underflow && !stat_overflow, "R12", "flags in reset",
        64'({stat_underflow, stat_overflow}), 64'h0);
    rst_n = 1'b1;

    // table walk (first idle word also proves the calendar starts at 0: R12)
    for (int i = 0; i < NV; i++) step(TBL[i], {32'hDA7A_0000, 32'(i)});

    // R4: an idle word restarts the burst count
    for (int i = 0; i < 3; i++)
      step(mkv(1,0,0,0,0,1,0, 1,0, 0,0,0,0), 64'h4000 + 64'(i));
    step(mkv(0,0,0,0,0,1,0, 1,1, 0,0,0,0), 64'h0);
    for (int i = 0; i < 3; i++)   // R4: three more data words, no burst word
      step(mkv(1,0,0,0,0,1,0, 1,0, 0,0,0,0), 64'h4100 + 64'(i));
    step(mkv(1,0,0,0,0,1,0, 0,2, 0,0,0,0), 64'h4200);  // R3 limit again
    step(mkv(1,0,0,0,0,1,0, 1,0, 0,0,0,0), 64'h4200);

    // R3 with a limit of 1: alternating data and burst words
    cfg_burst_max = 8'd1;
    for (int i = 0; i < 3; i++) begin
      step(mkv(1,0,0,0,0,1,0, 0,2, 0,0,0,0), 64'h5000 + 64'(i));
      step(mkv(1,0,0,0,0,1,0, 1,0, 0,0,0,0), 64'h5000 + 64'(i));
    end

    // R5/R6: run the calendar past its wrap
    for (int i = 0; i < 40; i++) step(mkv(0,0,0,0,0,1,0, 1,1, 0,0,0,0), 64'h0);
    chk(wraps >= 1, "R6", "calendar wrapped", 64'(wraps), 64'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule